// File: doc/BRIEF.md
# Programmable Local Bus Cycle Timer

This block turns one host access request into a single read or write cycle on a peripheral-side local bus. A request holds the address, the direction and the write data. Once the host shows its first initiator-ready of that transaction, the block counts host clock cycles from a reference cycle. The reference cycle is the second clock after that handshake. Every local-bus edge is then placed at a programmed offset from the reference cycle. The edges covered are chip-select, strobe and data-bus direction.

Two control styles are supported. The first uses separate active-low read and write strobes. The second uses one active-low data strobe together with an active-low read-not-write level. A 4-bit idle policy chooses between two behaviours. In the first, the data bus is kept driven between cycles and floated only inside a programmed read window. In the second, it is driven only around writes. While configuration loading is in progress, the data bus is never driven. Each cycle ends with a one-clock done pulse, and read data is captured when the strobe falls away.

Top module: `lbus_cycle_timer`

## Requirements
- R1: After reset, and whenever no cycle runs, the outputs are idle: lb_cs_n, lb_rd_n, lb_wr_n, lb_ds_n and lb_rdwr_n are 1, done is 0 and rdata is 0.
- R2: A request is taken in idle when req_valid is 1. Call E the first rising edge at which host_irdy is 1 (the request edge may itself be E). The reference cycle (offset t=0) is the second cycle after E. lb_addr shows the request address from t=0 and holds it to the end of the cycle.
- R3: lb_cs_n is 0 exactly for the offsets t with cfg_cs_on <= t < cfg_cs_off.
- R4: With cfg_moto=0, the strobe window is cfg_stb_on <= t < cfg_stb_off. In that window lb_rd_n is 0 for a read and lb_wr_n is 0 for a write. lb_ds_n and lb_rdwr_n stay 1.
- R5: With cfg_moto=1, lb_ds_n is 0 in the strobe window and lb_rd_n and lb_wr_n stay 1. lb_rdwr_n is 0 from t=0 to the end of a write cycle and stays 1 through a read.
- R6: With cfg_idle=4'hF, lb_oe is 1 in idle and through writes. During a read it is 0 exactly for cfg_rd_float <= t < cfg_rd_drive.
- R7: With cfg_idle other than 4'hF, lb_oe is 0 in idle and through reads, whatever cfg_rd_float and cfg_rd_drive hold. During a write it is 1 for cfg_turn <= t < cfg_stb_off + cfg_idle.
- R8: While cfg_loading is 1, lb_oe is 0 in every cycle.
- R9: On a read, rdata takes lb_din at the rising edge that ends offset t = cfg_stb_off - 1, and it holds that value at all other edges.
- R10: done is 1 for exactly the one cycle at offset t = L, after which the block is idle. L is the largest of cfg_cs_off, cfg_stb_off, cfg_stb_off + cfg_idle (a write with cfg_idle not 4'hF) and cfg_rd_drive (a read with cfg_idle = 4'hF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| host_irdy | input | 1 | Host initiator-ready |
| cfg_moto | input | 1 | 1 selects data strobe with read-not-write |
| cfg_loading | input | 1 | Configuration loading in progress |
| cfg_cs_on | input | TW | Chip-select assert offset |
| cfg_cs_off | input | TW | Chip-select release offset |
| cfg_stb_on | input | TW | Strobe assert offset |
| cfg_stb_off | input | TW | Strobe release offset |
| cfg_turn | input | TW | Write drive start offset (float policy) |
| cfg_idle | input | TW | Idle policy / write data hold count |
| cfg_rd_float | input | TW | Read float start offset (drive policy) |
| cfg_rd_drive | input | TW | Read drive-again offset (drive policy) |
| lb_din | input | DW | Local data bus input |
| lb_addr | output | AW | Local address |
| lb_dout | output | DW | Local data bus output |
| lb_oe | output | 1 | Data bus output enable |
| lb_cs_n | output | 1 | Chip select, active low |
| lb_rd_n | output | 1 | Read strobe, active low |
| lb_wr_n | output | 1 | Write strobe, active low |
| lb_ds_n | output | 1 | Data strobe, active low |
| lb_rdwr_n | output | 1 | Read-not-write, low for write |
| done | output | 1 | Cycle complete pulse |
| rdata | output | DW | Captured read data |

## Verification
The bench drives lb_din with a value that changes on every offset. A design that samples read data one edge early or late therefore returns a wrong word. Requests are sent with host_irdy already high and with it delayed, so a design that counts the reference from the request instead of from the handshake shifts every edge. The two idle policies are each run with reads and writes, and the read turnaround offsets are set to odd values under the float policy. A design that still honours those offsets, or that keeps driving after a write's hold, shows a wrong lb_oe. Long offsets, a chip-select that outlasts the strobe, and the loading input check the end-of-cycle choice and the forced float.

// File: rtl/lbct_pkg.sv
// Package: shared types for the local bus cycle timer.
// Assumes nothing beyond the IEEE 1800-2017 language.
package lbct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // no cycle, waiting for a request
        ST_ARM  = 2'd1,  // request held, waiting for initiator-ready
        ST_LEAD = 2'd2,  // one clock between handshake and reference
        ST_RUN  = 2'd3   // offsets counted from the reference cycle
    } lbct_state_e;
endpackage

// File: rtl/lbct_seq.sv
// Module: cycle sequencer. Takes a request, waits for the first
// initiator-ready, inserts one lead clock and then counts offsets from
// the reference cycle until the supplied last edge. Assumes last_edge
// stays stable while a cycle runs.
module lbct_seq
    import lbct_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          host_irdy,
    input  logic [CW-1:0] last_edge,
    output lbct_state_e   state,
    output logic [CW-1:0] cnt,
    output logic          wr_q,
    output logic [AW-1:0] lb_addr,
    output logic [DW-1:0] wdata_q,
    output logic          done
);
    logic [AW-1:0] addr_hold;
    logic          run;

    assign run  = (state == ST_RUN);
    assign done = run && (cnt == last_edge);

    // State, offset counter and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            wr_q      <= 1'b0;
            addr_hold <= '0;
            wdata_q   <= '0;
            lb_addr   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q      <= req_write;
                        addr_hold <= req_addr;
                        wdata_q   <= req_wdata;
                        state     <= host_irdy ? ST_LEAD : ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (host_irdy) state <= ST_LEAD;
                end
                ST_LEAD: begin
                    state   <= ST_RUN;
                    cnt     <= '0;
                    lb_addr <= addr_hold;
                end
                default: begin
                    if (cnt == last_edge) state <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |-> $stable(lb_addr)); // R2
    AST_RUN_FROM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == '0) |-> $past(state) == ST_LEAD); // R2
endmodule

// File: rtl/lbct_strobe.sv
// Module: strobe decoder. Builds chip-select, the two control styles and
// the read-not-write level from the running offset. Assumes each assert
// offset is not larger than its release offset.
module lbct_strobe #(
    parameter int TW = 4,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic          wr_q,
    input  logic          moto,
    input  logic [TW-1:0] cs_on,
    input  logic [TW-1:0] cs_off,
    input  logic [TW-1:0] stb_on,
    input  logic [TW-1:0] stb_off,
    output logic          lb_cs_n,
    output logic          lb_rd_n,
    output logic          lb_wr_n,
    output logic          lb_ds_n,
    output logic          lb_rdwr_n
);
    localparam int PAD = CW - TW;

    logic cs_act;
    logic stb_act;

    // Offset windows for chip-select and strobe.
    always_comb begin
        cs_act  = run && (cnt >= {{PAD{1'b0}}, cs_on})
                      && (cnt <  {{PAD{1'b0}}, cs_off});
        stb_act = run && (cnt >= {{PAD{1'b0}}, stb_on})
                      && (cnt <  {{PAD{1'b0}}, stb_off});
    end

    // Control style selection.
    always_comb begin
        lb_cs_n   = !cs_act;
        lb_rd_n   = !(!moto && stb_act && !wr_q);
        lb_wr_n   = !(!moto && stb_act && wr_q);
        lb_ds_n   = !(moto && stb_act);
        lb_rdwr_n = !(moto && run && wr_q);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lb_rd_n && !lb_wr_n)); // R4
    AST_MOTO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        moto |-> (lb_rd_n && lb_wr_n)); // R5
    AST_READ_RNW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_q) |-> lb_rdwr_n); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (lb_cs_n && lb_rd_n && lb_wr_n && lb_ds_n)); // R1
endmodule

// File: rtl/lbct_bus.sv
// Module: data bus control. Applies the idle policy to the output enable
// and captures read data when the strobe window closes. Assumes the
// configuration inputs are stable while a cycle runs.
module lbct_bus #(
    parameter int TW = 4,
    parameter int DW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic          wr_q,
    input  logic          loading,
    input  logic [TW-1:0] idle_pol,
    input  logic [TW-1:0] turn,
    input  logic [TW-1:0] rd_float,
    input  logic [TW-1:0] rd_drive,
    input  logic [TW-1:0] stb_on,
    input  logic [TW-1:0] stb_off,
    input  logic [CW-1:0] wr_end,
    input  logic [DW-1:0] lb_din,
    output logic          lb_oe,
    output logic [DW-1:0] rdata
);
    localparam int           PAD       = CW - TW;
    localparam logic [TW-1:0] KEEP_CODE = {TW{1'b1}};

    logic keep;
    logic cap;

    assign keep = (idle_pol == KEEP_CODE);

    // Output enable per policy; loading overrides everything.
    always_comb begin
        if (loading) begin
            lb_oe = 1'b0;
        end else if (keep) begin
            lb_oe = !(run && !wr_q
                      && (cnt >= {{PAD{1'b0}}, rd_float})
                      && (cnt <  {{PAD{1'b0}}, rd_drive}));
        end else begin
            lb_oe = run && wr_q
                    && (cnt >= {{PAD{1'b0}}, turn})
                    && (cnt <  wr_end);
        end
    end

    // Capture point: last offset inside the strobe window of a read.
    assign cap = run && !wr_q
                 && (cnt >= {{PAD{1'b0}}, stb_on})
                 && ((cnt + 1'b1) == {{PAD{1'b0}}, stb_off});

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (cap) rdata <= lb_din;
    end

    AST_LOAD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> !lb_oe); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(rdata)); // R9
    AST_FLOAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!keep && !wr_q) |-> !lb_oe); // R7
    AST_KEEP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (keep && !loading && (wr_q || !run)) |-> lb_oe); // R6
endmodule

// File: rtl/lbus_cycle_timer.sv
// Module: top of the local bus cycle timer. Connects the sequencer, the
// strobe decoder and the data bus control, and works out the last edge
// of the running cycle. Assumes timing fields are consistent and stable
// for the length of a cycle; no checking is done here.
module lbus_cycle_timer
    import lbct_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          host_irdy,
    input  logic          cfg_moto,
    input  logic          cfg_loading,
    input  logic [TW-1:0] cfg_cs_on,
    input  logic [TW-1:0] cfg_cs_off,
    input  logic [TW-1:0] cfg_stb_on,
    input  logic [TW-1:0] cfg_stb_off,
    input  logic [TW-1:0] cfg_turn,
    input  logic [TW-1:0] cfg_idle,
    input  logic [TW-1:0] cfg_rd_float,
    input  logic [TW-1:0] cfg_rd_drive,
    input  logic [DW-1:0] lb_din,
    output logic [AW-1:0] lb_addr,
    output logic [DW-1:0] lb_dout,
    output logic          lb_oe,
    output logic          lb_cs_n,
    output logic          lb_rd_n,
    output logic          lb_wr_n,
    output logic          lb_ds_n,
    output logic          lb_rdwr_n,
    output logic          done,
    output logic [DW-1:0] rdata
);
    localparam int CW = TW + 1;

    lbct_state_e   state;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic          run;
    logic [CW-1:0] wr_end;
    logic [CW-1:0] last_edge;

    assign run = (state == ST_RUN);

    // Last programmed edge of the running cycle.
    always_comb begin
        wr_end    = {1'b0, cfg_stb_off} + {1'b0, cfg_idle};
        last_edge = ({1'b0, cfg_cs_off} > {1'b0, cfg_stb_off})
                    ? {1'b0, cfg_cs_off} : {1'b0, cfg_stb_off};
        if (cfg_idle != {TW{1'b1}}) begin
            if (wr_q && wr_end > last_edge) last_edge = wr_end;
        end else begin
            if (!wr_q && {1'b0, cfg_rd_drive} > last_edge)
                last_edge = {1'b0, cfg_rd_drive};
        end
    end

    lbct_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .host_irdy (host_irdy),
        .last_edge (last_edge),
        .state     (state),
        .cnt       (cnt),
        .wr_q      (wr_q),
        .lb_addr   (lb_addr),
        .wdata_q   (lb_dout),
        .done      (done)
    );

    lbct_strobe #(.TW(TW), .CW(CW)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cnt       (cnt),
        .wr_q      (wr_q),
        .moto      (cfg_moto),
        .cs_on     (cfg_cs_on),
        .cs_off    (cfg_cs_off),
        .stb_on    (cfg_stb_on),
        .stb_off   (cfg_stb_off),
        .lb_cs_n   (lb_cs_n),
        .lb_rd_n   (lb_rd_n),
        .lb_wr_n   (lb_wr_n),
        .lb_ds_n   (lb_ds_n),
        .lb_rdwr_n (lb_rdwr_n)
    );

    lbct_bus #(.TW(TW), .DW(DW), .CW(CW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cnt      (cnt),
        .wr_q     (wr_q),
        .loading  (cfg_loading),
        .idle_pol (cfg_idle),
        .turn     (cfg_turn),
        .rd_float (cfg_rd_float),
        .rd_drive (cfg_rd_drive),
        .stb_on   (cfg_stb_on),
        .stb_off  (cfg_stb_off),
        .wr_end   (wr_end),
        .lb_din   (lb_din),
        .lb_oe    (lb_oe),
        .rdata    (rdata)
    );

    AST_DONE_ENDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lb_cs_n); // R10
endmodule

// File: tb/lbus_cycle_timer_tb.sv
module lbus_cycle_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, host_irdy = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0, lb_din = '0;
    logic       cfg_moto = 1'b0, cfg_loading = 1'b0;
    logic [3:0] cfg_cs_on, cfg_cs_off, cfg_stb_on, cfg_stb_off;
    logic [3:0] cfg_turn, cfg_idle, cfg_rd_float, cfg_rd_drive;
    logic [7:0] lb_addr, lb_dout, rdata;
    logic       lb_oe, lb_cs_n, lb_rd_n, lb_wr_n, lb_ds_n, lb_rdwr_n, done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct { bit w; logic [7:0] a; logic [7:0] r; } sb_item_t;
    sb_item_t sbq[$];

    always #10 clk = ~clk;

    lbus_cycle_timer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .host_irdy(host_irdy),
        .cfg_moto(cfg_moto), .cfg_loading(cfg_loading),
        .cfg_cs_on(cfg_cs_on), .cfg_cs_off(cfg_cs_off),
        .cfg_stb_on(cfg_stb_on), .cfg_stb_off(cfg_stb_off),
        .cfg_turn(cfg_turn), .cfg_idle(cfg_idle),
        .cfg_rd_float(cfg_rd_float), .cfg_rd_drive(cfg_rd_drive),
        .lb_din(lb_din), .lb_addr(lb_addr), .lb_dout(lb_dout), .lb_oe(lb_oe),
        .lb_cs_n(lb_cs_n), .lb_rd_n(lb_rd_n), .lb_wr_n(lb_wr_n),
        .lb_ds_n(lb_ds_n), .lb_rdwr_n(lb_rdwr_n), .done(done), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    task automatic set_cfg(input bit moto, input bit load,
                           input int cson, input int csoff, input int ston,
                           input int stoff, input int trn, input int pol,
                           input int rf, input int rdv);
        cfg_moto = moto; cfg_loading = load;
        cfg_cs_on = 4'(cson); cfg_cs_off = 4'(csoff);
        cfg_stb_on = 4'(ston); cfg_stb_off = 4'(stoff);
        cfg_turn = 4'(trn); cfg_idle = 4'(pol);
        cfg_rd_float = 4'(rf); cfg_rd_drive = 4'(rdv);
    endtask

    function automatic logic [7:0] din_at(input logic [7:0] a, input int t);
        return a ^ (8'h40 + 8'(t));
    endfunction

    // Driver: pushes the expected result, runs one cycle, checks each offset.
    task automatic do_txn(input bit w, input logic [7:0] a,
                          input logic [7:0] d, input int dly);
        int  last;
        bit  keep;
        int  bad_cs = 0, bad_stb = 0, bad_mode = 0, bad_oe = 0, bad_done = 0;
        int  bad_addr = 0;
        sb_item_t it;
        keep = (cfg_idle == 4'hF);
        last = (cfg_cs_off > cfg_stb_off) ? int'(cfg_cs_off) : int'(cfg_stb_off);
        if (w && !keep && int'(cfg_stb_off) + int'(cfg_idle) > last)
            last = int'(cfg_stb_off) + int'(cfg_idle);
        if (!w && keep && int'(cfg_rd_drive) > last) last = int'(cfg_rd_drive);
        it.w = w; it.a = a; it.r = din_at(a, int'(cfg_stb_off) - 1);
        sbq.push_back(it);
        for (int i = 0; i <= dly; i++) begin
            @(negedge clk);
            req_valid = (i == 0); req_write = w; req_addr = a; req_wdata = d;
            host_irdy = (i == dly);
        end
        @(negedge clk);
        req_valid = 1'b0; host_irdy = 1'b0;
        chk(lb_cs_n && !done, "R2", "lead cycle quiet", {lb_cs_n, done}, 2'b10);
        for (int t = 0; t <= last; t++) begin
            bit cs_e, stb_e, oe_e;
            @(negedge clk);
            lb_din = din_at(a, t);
            cs_e  = (t >= int'(cfg_cs_on)) && (t < int'(cfg_cs_off));
            stb_e = (t >= int'(cfg_stb_on)) && (t < int'(cfg_stb_off));
            if (cfg_loading) oe_e = 1'b0;
            else if (keep) oe_e = w || !((t >= int'(cfg_rd_float)) && (t < int'(cfg_rd_drive)));
            else oe_e = w && (t >= int'(cfg_turn)) && (t < int'(cfg_stb_off) + int'(cfg_idle));
            if (lb_cs_n != !cs_e) bad_cs++;
            if (!cfg_moto) begin
                if (lb_rd_n != !(stb_e && !w) || lb_wr_n != !(stb_e && w)) bad_stb++;
                if (!lb_ds_n || !lb_rdwr_n) bad_mode++;
            end else begin
                if (lb_ds_n != !stb_e) bad_stb++;
                if (!lb_rd_n || !lb_wr_n || lb_rdwr_n != !w) bad_mode++;
            end
            if (lb_oe != oe_e) bad_oe++;
            if (done != (t == last)) bad_done++;
            if (lb_addr != a) bad_addr++;
        end
        chk(bad_addr == 0, "R2", "address from reference", bad_addr, 0);
        chk(bad_cs == 0, "R3", "chip-select window", bad_cs, 0);
        chk(bad_stb == 0, cfg_moto ? "R5" : "R4", "strobe window", bad_stb, 0);
        chk(bad_mode == 0, cfg_moto ? "R5" : "R4", "style levels", bad_mode, 0);
        chk(bad_oe == 0, cfg_loading ? "R8" : (keep ? "R6" : "R7"), "oe per offset", bad_oe, 0);
        chk(bad_done == 0, "R10", "done at last edge", bad_done, 0);
        @(negedge clk);
        chk(!done && lb_cs_n && lb_rd_n && lb_wr_n && lb_ds_n && lb_rdwr_n,
            "R1", "idle after cycle", {done, lb_cs_n}, 2'b01);
        chk(lb_oe == (keep && !cfg_loading), keep ? "R6" : "R7", "idle oe",
            lb_oe, keep && !cfg_loading);
    endtask

    // Monitor: pops the expected item on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                sb_item_t e;
                e = sbq.pop_front();
                chk(lb_addr == e.a, "R2", "address at done", lb_addr, e.a);
                if (!e.w) chk(rdata == e.r, "R9", "read capture", rdata, e.r);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R10", "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        set_cfg(0, 0, 0, 4, 1, 3, 0, 15, 0, 4);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lb_cs_n && lb_rd_n && lb_wr_n && lb_ds_n && lb_rdwr_n && !done,
            "R1", "reset strobes", {lb_cs_n, done}, 2'b10);
        chk(rdata == 8'h00, "R1", "reset rdata", rdata, 0);
        chk(lb_oe == 1'b1, "R6", "reset oe with keep policy", lb_oe, 1);

        do_txn(1, 8'h12, 8'h5A, 0);          // separate strobes, defaults
        do_txn(0, 8'h34, 8'h00, 2);          // read, delayed initiator-ready
        set_cfg(0, 0, 0, 7, 2, 4, 0, 15, 1, 6);
        do_txn(0, 8'h56, 8'h00, 0);          // chip-select outlasts strobe
        set_cfg(1, 0, 0, 5, 1, 4, 0, 15, 0, 5);
        do_txn(1, 8'h78, 8'hA5, 1);          // data strobe style, write
        do_txn(0, 8'h9A, 8'h00, 0);          // data strobe style, read
        set_cfg(0, 0, 0, 4, 1, 3, 1, 2, 3, 9);
        do_txn(1, 8'hBC, 8'h3C, 0);          // float policy, write hold
        do_txn(0, 8'hDE, 8'h00, 0);          // float policy, read offsets ignored
        set_cfg(1, 0, 1, 15, 2, 15, 3, 10, 0, 0);
        do_txn(1, 8'hF0, 8'hC3, 0);          // long offsets, write
        do_txn(0, 8'h0F, 8'h00, 3);          // long offsets, read
        set_cfg(0, 1, 0, 4, 1, 3, 0, 15, 0, 4);
        do_txn(1, 8'h21, 8'h99, 0);          // loading forces float
        do_txn(0, 8'h43, 8'h00, 0);
        set_cfg(0, 0, 0, 4, 1, 3, 0, 15, 0, 4);
        @(negedge clk);
        chk(lb_oe == 1'b1, "R8", "drive resumes after loading", lb_oe, 1);
        repeat (2) @(negedge clk);
        chk(sbq.size() == 0, "R10", "every request completed", sbq.size(), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule